// File: doc/BRIEF.md
# Broadcast Data Decoder Host Port (Two-Wire Slave)

This block is the host-side serial port of a broadcast data decoder. An external controller, acting as the two-wire (I2C) bus master, uses it in two ways. It writes a single control byte that selects the decoder's operating mode and data source. It reads back up to sixteen buffered data bytes in a single sequential burst. The block runs on the system clock. Both bus lines pass through two-flop synchronisers, and START and STOP are recognised on the synchronised copies.

The address has two bus positions, chosen by a strap input. Every START rewinds the read pointer to the first buffered byte. Each acknowledge from the master moves the pointer to the next byte. A not-acknowledge ends the burst and sends the slave back to listening. A busy flag tells the data-acquisition side that a transaction is in progress, so it can hold off buffer updates while a read is underway. The control byte is decoded into a three-bit source selector that the rest of the decoder consumes.

Top module: `bcast_i2c_slave`

## Requirements
- R1: With the strap low the slave answers 7-bit address 0x10 (write byte 0x20, read byte 0x21). With the strap high it answers 0x11 (0x22/0x23). Any other address gets no acknowledge and leaves busy low and the control byte untouched.
- R2: A write transaction is the address with the R/W bit 0, a slave ACK, one data byte, and a slave ACK. The data byte becomes the control byte. Further bytes in the same transaction get no ACK and do not change it.
- R3: Each START, repeated START included, resets the read pointer so that the next read begins at buffer byte 1 (`rd_buf_i[7:0]`).
- R4: Read bytes are shifted out MSB first. Buffer byte k (k = 1..16) is `rd_buf_i[8k-1 -: 8]`. A master ACK advances to byte k+1.
- R5: A master NACK ends the read. The slave releases SDA and ignores any further clocks until the next START.
- R6: Reads beyond byte 16 return 0xFF.
- R7: `src_sel_o` decodes the control byte. If bit 1 is 0 the result is 0 (line-16 mode). Otherwise, if bit 0 is 0 the result is 1 (packet format 2). Otherwise, if bit 2 is 0 the result is 2 (packet format 1). Otherwise, if bit 3 is 0 the result is 3 (header order A), else 4 (header order B).
- R8: After reset the control byte is 0x00, busy is low, and SDA is released.
- R9: Busy rises when the slave's own address is matched. It falls on STOP, on START, or on a master NACK.
- R10: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Selects bus address 0x10 (low) or 0x11 (high) |
| rd_buf_i | input | 128 | Sixteen read bytes, byte 1 in bits [7:0] |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| busy_o | output | 1 | Transaction in progress |
| ctrl_o | output | 8 | Control byte as last written |
| src_sel_o | output | 3 | Decoded data-source selector |

## Verification
The hardest state to reach from the ports is the pointer at its saturation limit: the master has to acknowledge sixteen bytes in one burst before the 0xFF fill appears. The bench therefore reads eighteen bytes in a single transaction. A repeated START issued right after a NACK, with no STOP in between, shows that the rewind is tied to START and not to STOP. Clocks sent after a NACK, and an extra data byte sent after the control byte, probe the ignore paths, with the bench watching that SDA is never pulled during them.

// File: rtl/bis_pkg.sv
package bis_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } bus_state_t;

  typedef enum logic [2:0] {
    SRC_LINE16 = 3'd0,
    SRC_FMT2   = 3'd1,
    SRC_FMT1   = 3'd2,
    SRC_HDR_A  = 3'd3,
    SRC_HDR_B  = 3'd4
  } src_t;

  // Control byte to data-source selector, priority from bit 1 downwards
  function automatic src_t decode_src(input logic [BYTE_W-1:0] c);
    if (!c[1])      return SRC_LINE16;
    else if (!c[0]) return SRC_FMT2;
    else if (!c[2]) return SRC_FMT1;
    else if (!c[3]) return SRC_HDR_A;
    else            return SRC_HDR_B;
  endfunction

  // Received address byte against base address with strap in bit 0
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic strap,
                                    input logic [6:0] base);
    return rx[7:1] == {base[6:1], strap};
  endfunction

  // Saturating pointer step; the limit value selects the fill byte
  function automatic int unsigned next_index(input int unsigned i,
                                             input int unsigned lim);
    return (i >= lim) ? lim : i + 1;
  endfunction

endpackage

// File: rtl/bis_line_sync.sv
module bis_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise =  synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] &  prev[0];
  assign start_ev =  synced[0] & prev[0] &  prev[1] & ~synced[1];
  assign stop_ev  =  synced[0] & prev[0] & ~prev[1] &  synced[1];
endmodule

// File: rtl/bis_byte_pick.sv
module bis_byte_pick #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic [NBYTES*8-1:0] buf_i,
  input  logic [IDX_W-1:0]    sel_i,
  output logic [7:0]          byte_o
);
  always_comb begin
    byte_o = 8'hFF;
    for (int k = 0; k < NBYTES; k++) begin
      if (sel_i == IDX_W'(k)) byte_o = buf_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/bis_ctrl_reg.sv
module bis_ctrl_reg
  import bis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [2:0]        src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_o <= '0;
    else if (wr_en) ctrl_o <= wr_data;
  end

  assign src_o = decode_src(ctrl_o);
endmodule

// File: rtl/bis_bus_fsm.sv
module bis_bus_fsm
  import bis_pkg::*;
#(
  parameter int         NBYTES    = 16,
  parameter int         IDX_W     = $clog2(NBYTES + 1),
  parameter logic [6:0] ADDR_BASE = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              addr_strap,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [IDX_W-1:0]  pick_idx,
  output logic              sda_pull,
  output logic              busy,
  output logic              ctrl_wr_ev,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              addr_hit_ev,
  output logic              nack_ev
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  bus_state_t        state;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [IDX_W-1:0]  idx;
  logic              rw;
  logic              ack_q;
  logic              byte_done;
  logic [IDX_W-1:0]  idx_step;

  assign byte_done   = scl_fall && (bitcnt == LAST_BIT);
  assign idx_step    = IDX_W'(next_index(int'(idx), NBYTES));
  assign pick_idx    = (state == ST_RACK) ? idx_step : idx;
  assign rx_byte     = shreg;
  assign addr_hit_ev = (state == ST_ADDR) && byte_done &&
                       addr_hit(shreg, addr_strap, ADDR_BASE);
  assign ctrl_wr_ev  = (state == ST_WR) && byte_done;
  assign nack_ev     = (state == ST_RACK) && scl_fall && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      idx      <= '0;
      rw       <= 1'b0;
      ack_q    <= 1'b0;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      idx      <= '0;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (addr_hit_ev) begin
              state    <= ST_AACK;
              rw       <= shreg[0];
              sda_pull <= 1'b1;
              busy     <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              state    <= ST_RD;
              txreg    <= tx_byte;
              sda_pull <= ~tx_byte[BYTE_W-1];
              bitcnt   <= BIT_W'(1);
            end else begin
              state    <= ST_WR;
              sda_pull <= 1'b0;
              bitcnt   <= '0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            state    <= ST_WACK;
            sda_pull <= 1'b1;
            bitcnt   <= '0;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              state    <= ST_RACK;
              sda_pull <= 1'b0;
              bitcnt   <= '0;
            end else begin
              sda_pull <= ~txreg[BYTE_W-2];
              txreg    <= {txreg[BYTE_W-2:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              state    <= ST_RD;
              idx      <= idx_step;
              txreg    <= tx_byte;
              sda_pull <= ~tx_byte[BYTE_W-1];
              bitcnt   <= BIT_W'(1);
            end else begin
              state    <= ST_IDLE;
              sda_pull <= 1'b0;
              busy     <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bcast_i2c_slave.sv
module bcast_i2c_slave
  import bis_pkg::*;
#(
  parameter int         NBYTES      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                addr_strap_i,
  input  logic [NBYTES*8-1:0] rd_buf_i,
  output logic                sda_pull_o,
  output logic                busy_o,
  output logic [7:0]          ctrl_o,
  output logic [2:0]          src_sel_o
);
  localparam int IDX_W = $clog2(NBYTES + 1);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic              addr_hit_ev;
  logic              nack_ev;
  logic              ctrl_wr_ev;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] tx_byte;
  logic [IDX_W-1:0]  pick_idx;

  bis_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bis_bus_fsm #(.NBYTES(NBYTES), .IDX_W(IDX_W), .ADDR_BASE(ADDR_BASE)) fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .addr_strap(addr_strap_i), .tx_byte(tx_byte), .pick_idx(pick_idx),
    .sda_pull(sda_pull_o), .busy(busy_o), .ctrl_wr_ev(ctrl_wr_ev),
    .rx_byte(rx_byte), .addr_hit_ev(addr_hit_ev), .nack_ev(nack_ev)
  );

  bis_byte_pick #(.NBYTES(NBYTES), .IDX_W(IDX_W)) pick_i (
    .buf_i(rd_buf_i), .sel_i(pick_idx), .byte_o(tx_byte)
  );

  bis_ctrl_reg ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_ev), .wr_data(rx_byte),
    .ctrl_o(ctrl_o), .src_o(src_sel_o)
  );
endmodule

// File: rtl/bcast_i2c_slave_chk.sv
module bcast_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic [7:0] ctrl_o,
  input logic [2:0] src_sel_o,
  input logic       addr_hit_ev,
  input logic       ctrl_wr_ev,
  input logic       nack_ev,
  input logic       start_ev,
  input logic       stop_ev
);
  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (ctrl_o == 8'h00 && !busy_o && !sda_pull_o));

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(addr_hit_ev));

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(stop_ev || start_ev || nack_ev));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(ctrl_wr_ev));

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(!scl_s));

  // R5
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !sda_pull_o && !busy_o);

  // R7
  src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_o <= 3'd4);
endmodule

bind bcast_i2c_slave bcast_i2c_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .busy_o(busy_o), .ctrl_o(ctrl_o), .src_sel_o(src_sel_o),
  .addr_hit_ev(addr_hit_ev), .ctrl_wr_ev(ctrl_wr_ev), .nack_ev(nack_ev),
  .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/bcast_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module bcast_i2c_slave_tb_top;
  localparam int H     = 20;
  localparam int SETTLE = 10;
  localparam int LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl_m = 1'b1;
  logic         sda_m = 1'b1;
  logic         strap = 1'b0;
  logic [127:0] rbuf;
  logic         sda_pull;
  logic         busy;
  logic [7:0]   ctrl;
  logic [2:0]   src;
  logic         sda_line;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int edge_cyc = 0;
  logic       exp_busy = 1'b0;
  logic [7:0] exp_ctrl = 8'h00;
  logic       pull_seen = 1'b0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  bcast_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .rd_buf_i(rbuf), .sda_pull_o(sda_pull),
    .busy_o(busy), .ctrl_o(ctrl), .src_sel_o(src)
  );

  function automatic logic [7:0] buf_val(input int k);
    return 8'((k * 59 + 149) % 256);
  endfunction

  function automatic logic [7:0] ref_read(input int k);
    return (k < 16) ? buf_val(k) : 8'hFF;
  endfunction

  function automatic logic [2:0] ref_src(input logic [7:0] c);
    if (c[1] == 1'b0) return 3'd0;
    if (c[0] == 1'b0) return 3'd1;
    if (c[2] == 1'b0) return 3'd2;
    if (c[3] == 1'b0) return 3'd3;
    return 3'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // reference model comparison on every clock once lines have settled
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sda_pull) pull_seen <= 1'b1;
    if (rst_n && (cyc - edge_cyc > SETTLE)) begin
      chk("R9 busy", {31'd0, busy}, {31'd0, exp_busy});
      chk("R2 ctrl", {24'd0, ctrl}, {24'd0, exp_ctrl});
      chk("R7 src", {29'd0, src}, {29'd0, ref_src(exp_ctrl)});
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_scl(input logic v);
    scl_m = v; edge_cyc = cyc;
  endtask

  task automatic set_sda(input logic v);
    sda_m = v; edge_cyc = cyc;
  endtask

  task automatic bus_start();
    set_sda(1'b1); hold(H);
    set_scl(1'b1); hold(H);
    set_sda(1'b0); exp_busy = 1'b0; hold(H);
    set_scl(1'b0); hold(H);
  endtask

  task automatic bus_stop();
    set_sda(1'b0); hold(H);
    set_scl(1'b1); hold(H);
    set_sda(1'b1); exp_busy = 1'b0; hold(H);
  endtask

  task automatic put_bit(input logic b);
    set_sda(b); hold(H);
    set_scl(1'b1); hold(H);
    set_scl(1'b0);
  endtask

  task automatic get_bit(output logic b);
    set_sda(1'b1); hold(H);
    set_scl(1'b1); hold(H/2);
    b = sda_line;
    hold(H/2);
    set_scl(1'b0);
  endtask

  task automatic send8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic addr_phase(input logic [7:0] a, input logic match, output logic acked);
    logic b;
    send8(a);
    exp_busy = match;
    get_bit(b);
    acked = ~b;
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic match,
                        input logic [7:0] d0, input int nd, input logic [7:0] d1);
    logic acked;
    logic b;
    bus_start();
    addr_phase(a, match, acked);
    chk("R1 address ack", {31'd0, acked}, {31'd0, match});
    if (nd >= 1) begin
      send8(d0);
      if (match) exp_ctrl = d0;
      get_bit(b);
      chk("R2 data ack", {31'd0, ~b}, {31'd0, match});
    end
    if (nd >= 2) begin
      send8(d1);
      get_bit(b);
      chk("R2 extra byte not acked", {31'd0, b}, 32'd1);
    end
    bus_stop();
    chk("R9 busy low after stop", {31'd0, busy}, 32'd0);
  endtask

  task automatic rd_txn(input int n, input logic do_stop, input string req);
    logic acked;
    logic [7:0] v;
    logic b;
    bus_start();
    addr_phase(strap ? 8'h23 : 8'h21, 1'b1, acked);
    chk("R1 read address ack", {31'd0, acked}, 32'd1);
    chk("R9 busy during read", {31'd0, busy}, 32'd1);
    for (int j = 0; j < n; j++) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(b);
        v[i] = b;
      end
      put_bit(j < n - 1 ? 1'b0 : 1'b1);
      if (j == n - 1) exp_busy = 1'b0;
      chk(req, {24'd0, v}, {24'd0, ref_read(j)});
    end
    hold(SETTLE + 2);
    chk("R5 released after NACK", {31'd0, sda_pull}, 32'd0);
    chk("R9 busy low after NACK", {31'd0, busy}, 32'd0);
    if (do_stop) bus_stop();
  endtask

  initial begin
    logic acked;
    for (int k = 0; k < 16; k++) rbuf[k*8 +: 8] = buf_val(k);
    hold(5);
    // R8 reset state while held in reset and after release
    chk("R8 ctrl reset", {24'd0, ctrl}, 32'd0);
    chk("R8 busy reset", {31'd0, busy}, 32'd0);
    chk("R8 sda reset", {31'd0, sda_pull}, 32'd0);
    rst_n = 1'b1;
    hold(5);
    chk("R7 src after reset", {29'd0, src}, 32'd0);

    // R2, R7: each decode branch
    wr_txn(8'h20, 1'b1, 8'h02, 1, 8'h00);
    chk("R7 format2", {29'd0, src}, 32'd1);
    wr_txn(8'h20, 1'b1, 8'h03, 1, 8'h00);
    chk("R7 format1", {29'd0, src}, 32'd2);
    wr_txn(8'h20, 1'b1, 8'h07, 1, 8'h00);
    chk("R7 header A", {29'd0, src}, 32'd3);
    wr_txn(8'h20, 1'b1, 8'hAF, 1, 8'h00);
    chk("R7 header B", {29'd0, src}, 32'd4);
    chk("R2 full byte stored", {24'd0, ctrl}, 32'hAF);

    // R2: second data byte ignored
    wr_txn(8'h20, 1'b1, 8'h0B, 2, 8'h55);
    chk("R2 ctrl after extra byte", {24'd0, ctrl}, 32'h0B);

    // R1: address of the other strap setting ignored
    wr_txn(8'h22, 1'b0, 8'h00, 1, 8'h00);
    chk("R1 ctrl unchanged on mismatch", {24'd0, ctrl}, 32'h0B);

    // R1: strap high moves the address
    strap = 1'b1;
    hold(4);
    wr_txn(8'h20, 1'b0, 8'h00, 1, 8'h00);
    wr_txn(8'h22, 1'b1, 8'h00, 1, 8'h00);
    chk("R7 line16 mode", {29'd0, src}, 32'd0);

    // R4: short read with NACK on third byte
    rd_txn(3, 1'b1, "R4 read byte");
    strap = 1'b0;
    hold(4);
    // R3: repeated start after NACK rewinds
    rd_txn(2, 1'b0, "R3 read byte");
    rd_txn(1, 1'b1, "R3 rewind byte 1");

    // R6: read beyond the end
    rd_txn(18, 1'b1, "R6 read byte");

    // R5: clocks after NACK must not be answered
    bus_start();
    addr_phase(8'h21, 1'b1, acked);
    for (int i = 0; i < 8; i++) begin
      logic b;
      get_bit(b);
    end
    put_bit(1'b1);
    exp_busy = 1'b0;
    hold(SETTLE + 2);
    pull_seen = 1'b0;
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    hold(SETTLE + 2);
    chk("R5 no drive after NACK", {31'd0, pull_seen}, 32'd0);
    chk("R5 busy stays low", {31'd0, busy}, 32'd0);
    bus_stop();

    // R10: START detected mid-idle, STOP ends busy during write
    bus_start();
    addr_phase(8'h20, 1'b1, acked);
    chk("R10 busy after match", {31'd0, busy}, 32'd1);
    bus_stop();
    hold(SETTLE + 2);
    chk("R10 stop clears busy", {31'd0, busy}, 32'd0);

    hold(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule